// File: doc/BRIEF.md
# NAND Read Strobe Timing Generator

This block drives the active-low read strobe of an asynchronous single-data-rate NAND flash port through a burst of byte reads, and it captures the 8-bit data bus once for each strobe. The timing inputs are already given in controller clock cycles: a high-phase setting, a minimum strobe-low width, a maximum data access time and a minimum whole read cycle. When a burst is accepted, the block turns these into a low-phase length and a capture delay.

The low phase is sized only from the pulse-width and cycle-time requirements, so the read cycle stays as short as the flash allows. When the flash needs longer to drive valid data than the low phase lasts, capture moves to a point up to three cycles after the strobe's rising edge. The strobe is not stretched in that case. Only an access gap of more than three cycles makes the low phase longer. The capture path is a separate pipeline, so a delayed sample can fall inside the next byte's low phase. Each captured byte comes out with a one-cycle valid pulse, and a one-cycle done pulse closes the burst.

Top module: `nand_rd_strobe`

## Requirements
- R1: After reset, and whenever `busy` is low, `re_n` is high. `rd_valid`, `done` and `viol` are low after reset.
- R2: During a burst each strobe-low phase lasts L cycles and each high phase lasts `cfg_twh`+1 cycles. L is the largest of 1, `cfg_rp`, and `cfg_rc` minus (`cfg_twh`+1) when that difference is positive. `cfg_rea` has no effect on L unless R5 applies.
- R3: L never exceeds 16. If the pulse-width and cycle-time step asks for more than 16, L is 16 and `viol` is set.
- R4: The capture delay D is `cfg_rea` minus L when `cfg_rea` exceeds L, and 0 otherwise. With D = 0 the byte is the value of `dq_in` in the last low cycle, taken at the rising clock edge where `re_n` rises. With D > 0 it is taken at the clock edge D cycles later.
- R5: If the R4 delay would exceed 3, D is 3 and the excess is added to L. If L then exceeds 16, L is 16 and `viol` is set.
- R6: Each captured byte appears on `rd_data` with `rd_valid` high for exactly the one cycle after its capture edge.
- R7: A burst of `cfg_len` bytes (`cfg_len` at least 1) gives exactly that many `rd_valid` pulses. `done` is high for one cycle, the cycle after the last `rd_valid`.
- R8: `start` is accepted only while `busy` is low. The timing and length inputs are latched on acceptance. A `start` pulse or a change of those inputs during a burst has no effect on that burst.
- R9: `viol` stays high once set, until reset.
- R10: Captures delayed beyond the high phase still deliver every byte in order with its own data, because sampling runs independently of the strobe sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a burst |
| cfg_twh | input | 4 | High-phase setting; the high phase is this value plus one cycles |
| cfg_rp | input | TW (6) | Minimum strobe-low width in cycles |
| cfg_rea | input | TW (6) | Maximum data access time in cycles, rounded up |
| cfg_rc | input | TW (6) | Minimum total read cycle in cycles |
| cfg_len | input | NW (8) | Number of bytes in the burst |
| dq_in | input | 8 | NAND data bus |
| re_n | output | 1 | Active-low read strobe to the flash |
| busy | output | 1 | A burst is running or still delivering captured bytes |
| done | output | 1 | One-cycle pulse that ends a burst |
| rd_valid | output | 1 | One-cycle pulse marking a captured byte |
| rd_data | output | 8 | Captured byte |
| viol | output | 1 | Sticky flag: a timing request could not be met |

## Verification
The assertions assume that `start` is held for no longer than needed and that `cfg_len` is at least 1. They also assume that reset is held for at least one clock edge before the first burst. The bench only starts a burst after it has seen `done` and `busy` low. It uses burst lengths from 1 upward and drives the timing inputs within their port widths, including settings that saturate the low phase. It changes the timing inputs and pulses `start` during a burst only to check that these changes are ignored.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    localparam int LOW_MAX = 16;
    localparam int DLY_MAX = 3;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LOW  = 2'd1,
        SQ_HIGH = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic [4:0] low_len;
        logic [4:0] high_len;
        logic [1:0] dly;
        logic       viol;
    } nrs_timing_t;

    typedef struct packed {
        logic fire;
        logic last;
    } cap_tok_t;

endpackage

// File: rtl/nrs_timing_calc.sv
module nrs_timing_calc
    import nrs_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic [3:0]    twh,
    input  logic [TW-1:0] rp,
    input  logic [TW-1:0] rea,
    input  logic [TW-1:0] rc,
    output nrs_timing_t   tim
);
    localparam int WW = TW + 3;
    localparam logic [WW-1:0] CAP = WW'(LOW_MAX);
    localparam logic [WW-1:0] DMX = WW'(DLY_MAX);

    logic [WW-1:0] h_len, rc_w, rp_w, rea_w;
    logic [WW-1:0] rem, need, base, gap, spill, low2;
    logic          v_base, v_spill;

    always_comb begin
        h_len = WW'(twh) + WW'(1);
        rc_w  = WW'(rc);
        rp_w  = WW'(rp);
        rea_w = WW'(rea);

        rem  = (rc_w > h_len) ? rc_w - h_len : '0;
        need = (rp_w > rem) ? rp_w : rem;
        if (need == '0) need = WW'(1);

        v_base = need > CAP;
        base   = v_base ? CAP : need;

        gap = (rea_w > base) ? rea_w - base : '0;
        if (gap > DMX) begin
            spill   = gap - DMX;
            tim.dly = 2'(DLY_MAX);
        end else begin
            spill   = '0;
            tim.dly = gap[1:0];
        end

        low2    = base + spill;
        v_spill = low2 > CAP;

        tim.low_len  = v_spill ? 5'(LOW_MAX) : low2[4:0];
        tim.high_len = 5'(h_len);
        tim.viol     = v_base | v_spill;
    end

endmodule

// File: rtl/nrs_sequencer.sv
module nrs_sequencer
    import nrs_pkg::*;
#(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [4:0]    low_len,
    input  logic [4:0]    high_len,
    input  logic [NW-1:0] len,
    output logic          re_n,
    output logic          rise,
    output logic          rise_last,
    output logic          active
);
    sq_state_e     st;
    logic [3:0]    cnt;
    logic [3:0]    lo_q;
    logic [3:0]    hi_q;
    logic [NW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            cnt  <= '0;
            lo_q <= '0;
            hi_q <= '0;
            left <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (go) begin
                        lo_q <= 4'(low_len - 5'd1);
                        hi_q <= 4'(high_len - 5'd1);
                        cnt  <= 4'(low_len - 5'd1);
                        left <= (len == '0) ? '0 : len - NW'(1);
                        st   <= SQ_LOW;
                    end
                end
                SQ_LOW: begin
                    if (cnt == '0) begin
                        st  <= SQ_HIGH;
                        cnt <= hi_q;
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                SQ_HIGH: begin
                    if (cnt == '0) begin
                        if (left == '0) begin
                            st <= SQ_IDLE;
                        end else begin
                            st   <= SQ_LOW;
                            cnt  <= lo_q;
                            left <= left - NW'(1);
                        end
                    end else begin
                        cnt <= cnt - 4'd1;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign re_n      = (st != SQ_LOW);
    assign rise      = (st == SQ_LOW) && (cnt == '0);
    assign rise_last = rise && (left == '0);
    assign active    = (st != SQ_IDLE);

endmodule

// File: rtl/nrs_capture.sv
module nrs_capture
    import nrs_pkg::*;
#(
    parameter int DEPTH = DLY_MAX
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rise,
    input  logic       rise_last,
    input  logic [1:0] dly,
    input  logic [7:0] dq,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_last
);
    cap_tok_t tok [DEPTH];
    cap_tok_t head;
    cap_tok_t sel;

    assign head = '{fire: rise, last: rise_last};

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) tok[g] <= '0;
                else     tok[g] <= head;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) tok[g] <= '0;
                else     tok[g] <= tok[g-1];
            end
        end
    end

    always_comb begin
        sel = head;
        for (int k = 1; k <= DEPTH; k++) begin
            if (int'(dly) == k) sel = tok[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= sel.fire;
            rd_last  <= sel.fire & sel.last;
            if (sel.fire) rd_data <= dq;
        end
    end

endmodule

// File: rtl/nand_rd_strobe.sv
module nand_rd_strobe
    import nrs_pkg::*;
#(
    parameter int TW = 6,
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [3:0]    cfg_twh,
    input  logic [TW-1:0] cfg_rp,
    input  logic [TW-1:0] cfg_rea,
    input  logic [TW-1:0] cfg_rc,
    input  logic [NW-1:0] cfg_len,
    input  logic [7:0]    dq_in,
    output logic          re_n,
    output logic          busy,
    output logic          done,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          viol
);
    nrs_timing_t tim;
    logic        busy_q;
    logic        seq_active;
    logic        accept;
    logic        rise, rise_last;
    logic        cap_last;
    logic [1:0]  dly_q;

    nrs_timing_calc #(.TW(TW)) u_calc (
        .twh (cfg_twh),
        .rp  (cfg_rp),
        .rea (cfg_rea),
        .rc  (cfg_rc),
        .tim (tim)
    );

    assign accept = start & ~busy_q & ~seq_active;

    nrs_sequencer #(.NW(NW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (accept),
        .low_len   (tim.low_len),
        .high_len  (tim.high_len),
        .len       (cfg_len),
        .re_n      (re_n),
        .rise      (rise),
        .rise_last (rise_last),
        .active    (seq_active)
    );

    nrs_capture #(.DEPTH(DLY_MAX)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .rise_last (rise_last),
        .dly       (dly_q),
        .dq        (dq_in),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_last   (cap_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done   <= 1'b0;
            viol   <= 1'b0;
            dly_q  <= '0;
        end else begin
            done <= rd_valid & cap_last;
            if (accept) begin
                busy_q <= 1'b1;
                dly_q  <= tim.dly;
                if (tim.viol) viol <= 1'b1;
            end else if (rd_valid & cap_last) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q | seq_active;

endmodule

// File: rtl/nrs_checker.sv
module nrs_checker (
    input logic clk,
    input logic rst,
    input logic re_n,
    input logic busy,
    input logic done,
    input logic rd_valid,
    input logic viol
);
    logic [4:0] lowrun;

    always_ff @(posedge clk) begin
        if (rst)          lowrun <= '0;
        else if (re_n)    lowrun <= '0;
        else if (lowrun != 5'd31) lowrun <= lowrun + 5'd1;
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> re_n);

    p_low_cap_r3: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> (lowrun < 5'd16));

    p_valid_in_burst_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> busy);

    p_done_after_valid_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rd_valid));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_viol_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        viol |=> viol);

endmodule

bind nand_rd_strobe nrs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .re_n     (re_n),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .viol     (viol)
);

// File: tb/sim_nand_rd_strobe.sv
`timescale 1ns/1ps
module sim_nand_rd_strobe;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] cfg_twh = '0;
    logic [5:0] cfg_rp = '0, cfg_rea = '0, cfg_rc = '0;
    logic [7:0] cfg_len = '0;
    logic [7:0] dq_in = '0;
    logic       re_n, busy, done, rd_valid, viol;
    logic [7:0] rd_data;

    always #5 clk = ~clk;

    nand_rd_strobe u0 (
        .clk(clk), .rst(rst), .start(start), .cfg_twh(cfg_twh),
        .cfg_rp(cfg_rp), .cfg_rea(cfg_rea), .cfg_rc(cfg_rc),
        .cfg_len(cfg_len), .dq_in(dq_in), .re_n(re_n), .busy(busy),
        .done(done), .rd_valid(rd_valid), .rd_data(rd_data), .viol(viol)
    );

    typedef struct {
        int         tick;
        logic [7:0] data;
    } exp_t;

    exp_t q[$];
    int   checks = 0, failures = 0;
    int   tick = 0;
    int   exp_low = 0, exp_high = 0, exp_done = -1;
    bit   done_seen = 1'b0;
    int   lowrun = 0, highrun = 0;
    bit   hact = 1'b0;
    bit   exp_viol = 1'b0;
    bit   finished = 1'b0;

    function automatic logic [7:0] pat(input int t);
        return 8'(t * 29 + 7);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: pattern driver for dq and result comparison.
    always @(negedge clk) begin
        tick = tick + 1;
        dq_in = pat(tick);
        if (!rst) begin
            if (rd_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7 extra byte", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(tick == e.tick, "R6 valid timing", tick, e.tick);
                    chk(rd_data == e.data, "R4/R5/R10 data", int'(rd_data), int'(e.data));
                end
            end
            if (done) begin
                chk(tick == exp_done, "R7 done timing", tick, exp_done);
                chk(q.size() == 0, "R7 bytes before done", q.size(), 0);
                done_seen = 1'b1;
                exp_done = -1;
                hact = 1'b0;
            end
            if (!re_n) begin
                if (hact) begin
                    chk(highrun == exp_high, "R2 high phase", highrun, exp_high);
                    hact = 1'b0;
                end
                lowrun++;
            end else begin
                if (lowrun > 0) begin
                    chk(lowrun == exp_low, "R2/R3/R5 low phase", lowrun, exp_low);
                    lowrun = 0;
                    hact = 1'b1;
                    highrun = 0;
                end
                if (hact) highrun++;
            end
        end
    end

    task automatic run_burst(input int twh, input int rp, input int rea,
                             input int rc, input int n, input bit disturb);
        int h, l, d, rem, t0, c;
        h = twh + 1;
        rem = (rc > h) ? rc - h : 0;
        l = (rp > rem) ? rp : rem;
        if (l < 1) l = 1;
        if (l > 16) begin l = 16; exp_viol = 1'b1; end
        d = (rea > l) ? rea - l : 0;
        if (d > 3) begin l = l + d - 3; d = 3; end
        if (l > 16) begin l = 16; exp_viol = 1'b1; end

        @(negedge clk); #1;
        cfg_twh = 4'(twh); cfg_rp = 6'(rp); cfg_rea = 6'(rea);
        cfg_rc = 6'(rc); cfg_len = 8'(n);
        start = 1'b1;
        t0 = tick;
        exp_low = l; exp_high = h; done_seen = 1'b0;
        c = 0;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            c = i * (l + h) + l + d;
            e.tick = t0 + c + 1;
            e.data = pat(t0 + c);
            q.push_back(e);
        end
        exp_done = t0 + c + 2;
        @(negedge clk); #1;
        start = 1'b0;
        if (disturb) begin
            // R8: new settings and a second start during the burst are ignored
            repeat (2) @(negedge clk);
            #1;
            cfg_twh = 4'd9; cfg_rp = 6'd30; cfg_rea = 6'd1; cfg_rc = 6'd2; cfg_len = 8'd7;
            start = 1'b1;
            @(negedge clk); #1;
            start = 1'b0;
        end
        for (int k = 0; k < 3000 && !done_seen; k++) @(negedge clk);
        chk(done_seen, "R7 done seen", int'(done_seen), 1);
        for (int k = 0; k < 100 && busy; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R7/R8 byte count", q.size(), 0);
        chk(re_n == 1'b1 && busy == 1'b0, "R1 idle after burst", int'(re_n), 1);
        chk(viol == exp_viol, "R3/R5/R9 viol", int'(viol), int'(exp_viol));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(re_n == 1'b1, "R1 reset re_n", int'(re_n), 1);
        chk(rd_valid == 1'b0 && done == 1'b0, "R1 reset pulses", int'(rd_valid | done), 0);
        chk(viol == 1'b0 && busy == 1'b0, "R1 reset flags", int'(viol | busy), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_burst(1, 2, 2, 4, 3, 1'b0);   // R2 L=2, R4 D=0
        run_burst(0, 1, 3, 2, 5, 1'b0);   // R4 D=2, R10 across short high phase
        run_burst(1, 2, 9, 3, 4, 1'b0);   // R5 spill: L=6, D=3
        run_burst(0, 1, 4, 0, 6, 1'b1);   // R10 D=3 with 1-cycle phases, R8 disturb
        run_burst(0, 1, 8, 8, 2, 1'b0);   // R2 cycle time sets L=7, D=1
        run_burst(3, 5, 0, 0, 1, 1'b0);   // R7 single byte, R2 rea ignored
        run_burst(2, 20, 5, 0, 2, 1'b0);  // R3 saturate at 16
        run_burst(1, 2, 2, 4, 2, 1'b0);   // R9 flag stays set

        @(negedge clk); #1;
        rst = 1'b1;
        exp_viol = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(viol == 1'b0, "R9 cleared by reset", int'(viol), 0);
        rst = 1'b0;
        @(negedge clk);
        run_burst(0, 15, 25, 0, 2, 1'b0); // R5 spill saturates, viol set

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule